// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

A single-channel engine that moves a block of words between system memory and one peripheral data port while the processor keeps running. Software loads a start address and a word count, then writes a control word holding the transfer direction and the peripheral's identifier. That control write launches the block.

The engine never keeps the shared bus for the whole block. For each word it raises a bus request and waits for the processor's grant. It then spends one granted cycle on that word, driving the memory and port strobes together so the data goes straight from one side to the other. After that word it drops the request again. The address advances and the count falls with every word. When the count reaches zero a sticky interrupt is raised, and it stays up until software writes the clear register.

Top module: `dma_steal`

## Requirements
- R1: After reset, `hold_o`, `irq_o` and `busy_o` are low and every bus and port output is zero.
- R2: `cfg_sel_i` picks the register that `cfg_we_i` writes: 0 is the start address, 1 is the word count, 2 is control and 3 clears status. In the control word, bit 0 is the direction (1 = port to memory, 0 = memory to port) and bits [DEV_W:1] are the device identifier. A control write with a nonzero count sets `busy_o` in the next cycle.
- R3: A memory or port strobe, a nonzero `mem_addr_o` or a nonzero `dev_sel_o` appears only in a cycle where both `hold_o` and `hlda_i` are high.
- R4: Each raised request carries exactly one word. `hold_o` is low in the cycle that follows a word's strobe cycle, and the number of requests equals the word count.
- R5: Word k of a block uses address (start + k) modulo 2^ADDR_W, and `dev_sel_o` carries the programmed identifier during every word.
- R6: With direction 1, `dev_rd_o` and `mem_we_o` pulse in the same cycle and `mem_wdata_o` equals `dev_rdata_i`. With direction 0, `mem_re_o` and `dev_wr_o` pulse together and `dev_wdata_o` equals `mem_rdata_i`.
- R7: `hold_o` rises only when `dev_ready_i` was high and `hlda_i` was low in the cycle before. While `dev_ready_i` stays low, no request is made.
- R8: In the edge that ends the last word, `irq_o` rises and `busy_o` falls together, and exactly the programmed number of words has been moved.
- R9: A control write with a count of zero raises `irq_o` in the next cycle and never raises `hold_o`.
- R10: `irq_o` stays high until a write to the clear register while the engine is idle. It is low in the cycle after that write.
- R11: Writes to any register while `busy_o` is high are ignored. The running block keeps its address, count, direction and identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe from the processor |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | CFG_W | Register write data |
| busy_o | output | 1 | Block in progress |
| irq_o | output | 1 | Sticky completion interrupt |
| hold_o | output | 1 | Bus request to the processor |
| hlda_i | input | 1 | Bus grant from the processor |
| mem_addr_o | output | ADDR_W | Memory address during a word |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the same cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| dev_sel_o | output | DEV_W | Device identifier during a word |
| dev_ready_i | input | 1 | Port has a word (inbound) or room (outbound) |
| dev_rd_o | output | 1 | Take one word from the port |
| dev_rdata_i | input | DATA_W | Port data toward memory |
| dev_wr_o | output | 1 | Give one word to the port |
| dev_wdata_o | output | DATA_W | Port data from memory |

## Verification
The bench grants the bus after a random delay and toggles port readiness at random. This checks that a design which keeps the bus for several words, or requests without a ready port, shows more words per request or a request while the port is idle. A one-word block and a block whose addresses run past the top of the address space expose off-by-one count ends and wrong address wrapping. Zero-count starts, interrupts held across several cycles before clearing, and garbage register writes in the middle of a block catch designs that start the bus on an empty block, lose the interrupt early, or let a busy write corrupt the address or memory outside the target region.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PACE,
    ST_REQ,
    ST_MOVE
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_CLEAR = 2'd3;
endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int DEV_W  = 4,
  parameter int CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              busy_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dir_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic              start_o,
  output logic              last_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dir_q;
  logic [DEV_W-1:0]  dev_q;
  logic              irq_q;
  logic              wr_ok, ctrl_wr, zero_go, clr_wr;

  assign wr_ok   = cfg_we_i && !busy_i;
  assign ctrl_wr = wr_ok && (cfg_sel_i == SEL_CTRL);
  assign clr_wr  = wr_ok && (cfg_sel_i == SEL_CLEAR);
  assign start_o = ctrl_wr && (cnt_q != '0);
  assign zero_go = ctrl_wr && (cnt_q == '0);
  assign last_o  = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      dev_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ok && cfg_sel_i == SEL_ADDR) addr_q <= cfg_wdata_i[ADDR_W-1:0];
      else if (step_i)                    addr_q <= addr_q + 1'b1;

      if (wr_ok && cfg_sel_i == SEL_COUNT) cnt_q <= cfg_wdata_i[CNT_W-1:0];
      else if (step_i)                     cnt_q <= cnt_q - 1'b1;

      if (ctrl_wr) begin
        dir_q <= cfg_wdata_i[0];
        dev_q <= cfg_wdata_i[DEV_W:1];
      end

      if ((step_i && last_o) || zero_go) irq_q <= 1'b1;
      else if (clr_wr)                   irq_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign dir_o  = dir_q;
  assign dev_o  = dev_q;
  assign irq_o  = irq_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> addr_q == $past(addr_q) + 1'b1); // R5
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_q == $past(cnt_q) - 1'b1); // R8
  AST_NO_STEP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q != '0); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_wr) |=> irq_q); // R10
  AST_LOCKED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(dir_q) && $stable(dev_q)); // R11
endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_steal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  input  logic ready_i,
  input  logic hlda_i,
  output logic busy_o,
  output logic hold_o,
  output logic step_o
);
  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_PACE;
      // wait for port readiness and for the previous grant to be withdrawn
      ST_PACE: if (ready_i && !hlda_i) state_d = ST_REQ;
      ST_REQ:  if (hlda_i) state_d = ST_MOVE;
      ST_MOVE: if (hlda_i) state_d = last_i ? ST_IDLE : ST_PACE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign hold_o = (state_q == ST_REQ) || (state_q == ST_MOVE);
  assign step_o = (state_q == ST_MOVE) && hlda_i;

  AST_PACED_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(ready_i && !hlda_i)); // R7
  AST_RELEASE_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !hold_o); // R4
endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_steal_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int DEV_W  = 4,
  parameter int CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              hold_o,
  input  logic              hlda_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [DEV_W-1:0]  dev_sel_o,
  input  logic              dev_ready_i,
  output logic              dev_rd_o,
  input  logic [DATA_W-1:0] dev_rdata_i,
  output logic              dev_wr_o,
  output logic [DATA_W-1:0] dev_wdata_o
);
  logic [ADDR_W-1:0] addr;
  logic [DEV_W-1:0]  dev;
  logic              dir, start, last, step, busy;
  logic              in_word, out_word;

  dma_steal_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .CFG_W(CFG_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .busy_i      (busy),
    .step_i      (step),
    .addr_o      (addr),
    .dir_o       (dir),
    .dev_o       (dev),
    .start_o     (start),
    .last_o      (last),
    .irq_o       (irq_o)
  );

  dma_steal_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .last_i  (last),
    .ready_i (dev_ready_i),
    .hlda_i  (hlda_i),
    .busy_o  (busy),
    .hold_o  (hold_o),
    .step_o  (step)
  );

  // buses stay zero outside the single granted word slot
  assign in_word  = step && dir;
  assign out_word = step && !dir;

  assign busy_o      = busy;
  assign mem_addr_o  = step ? addr : '0;
  assign dev_sel_o   = step ? dev : '0;
  assign mem_we_o    = in_word;
  assign dev_rd_o    = in_word;
  assign mem_re_o    = out_word;
  assign dev_wr_o    = out_word;
  assign mem_wdata_o = in_word ? dev_rdata_i : '0;
  assign dev_wdata_o = out_word ? mem_rdata_i : '0;

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_o && hlda_i) |-> !(mem_we_o || mem_re_o || dev_rd_o || dev_wr_o)
                            && mem_addr_o == '0 && dev_sel_o == '0); // R3
  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o})); // R6
  AST_IDLE_NO_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !hold_o); // R9
endmodule

// File: tb/dma_steal_tb.sv
`timescale 1ns/1ps
module dma_steal_tb;
  localparam int AW = 10, DW = 16, CW = 8, VW = 4, FW = 16;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [FW-1:0] cfg_wdata = '0;
  logic busy, irq, hold, hlda;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic mem_we, mem_re, dev_rd, dev_wr, dev_ready;
  logic [VW-1:0] dev_sel;

  always #2.5 clk = ~clk;

  dma_steal #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .DEV_W(VW), .CFG_W(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .busy_o(busy), .irq_o(irq), .hold_o(hold),
    .hlda_i(hlda), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .dev_sel_o(dev_sel), .dev_ready_i(dev_ready), .dev_rd_o(dev_rd),
    .dev_rdata_i(dev_rdata), .dev_wr_o(dev_wr), .dev_wdata_o(dev_wdata));

  function automatic logic [DW-1:0] dev_word(int i);
    return DW'((i * 32'h1357) ^ 32'h5a00);
  endfunction
  function automatic logic [DW-1:0] mem_word(int i);
    return DW'((i * 32'h2b) ^ 32'hc3c3);
  endfunction

  int total = 0, bad = 0, cyc = 0;
  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory stub: combinational read, clocked write
  logic [DW-1:0] mem [0:MEMN-1];
  logic [DW-1:0] exp_mem [0:MEMN-1];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  // processor grant model with random latency
  int gdly;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin hlda <= 1'b0; gdly <= 0; end
    else if (!hold) begin hlda <= 1'b0; gdly <= int'($urandom % 4); end
    else if (!hlda) begin
      if (gdly == 0) hlda <= 1'b1; else gdly <= gdly - 1;
    end
  end

  // port stub
  bit ready_block = 1'b0;
  int src_idx = 0, out_n = 0;
  logic [DW-1:0] out_buf [0:255];
  assign dev_rdata = dev_word(src_idx);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) dev_ready <= 1'b0;
    else dev_ready <= ready_block ? 1'b0 : (hold ? 1'b1 : ($urandom % 3 != 0));
  end
  always @(posedge clk) begin
    if (dev_rd) src_idx <= src_idx + 1;
    if (dev_wr) begin out_buf[out_n % 256] <= dev_wdata; out_n <= out_n + 1; end
  end

  // bus monitor
  int strobes = 0, grants = 0, snap = 0, mon_base = 0, ep_words = 0;
  logic [VW-1:0] mon_dev = '0;
  int drive_err = 0, addr_err = 0, dir_err = 0, multi_err = 0, pace_err = 0;
  bit p_hold = 0, p_strobe = 0, p_ready = 0, p_hlda = 0;
  always @(negedge clk) if (rst_n) begin
    automatic bit st = mem_we | mem_re;
    if (hold && !p_hold) begin
      grants++; ep_words = 0;
      if (!p_ready || p_hlda) pace_err++;
    end
    if (st) begin
      if (!(hold && hlda)) drive_err++;
      if (mem_addr != AW'(mon_base + strobes - snap)) addr_err++;
      if (dev_sel != mon_dev) addr_err++;
      if (dev_rd != mem_we || dev_wr != mem_re) dir_err++;
      if (mem_we && mem_wdata != dev_rdata) dir_err++;
      if (mem_re && dev_wdata != mem_rdata) dir_err++;
      strobes++; ep_words++;
      if (ep_words > 1) multi_err++;
    end else if (mem_addr != '0 || dev_sel != '0 || dev_rd || dev_wr) drive_err++;
    if (p_strobe && hold) multi_err++;
    p_hold = hold; p_strobe = st; p_ready = dev_ready; p_hlda = hlda;
  end

  task automatic cfg_write(logic [1:0] sel, logic [FW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
  endtask

  int g0, s0, src0, o0, x_n, x_start;
  bit x_dir;

  task automatic start_xfer(bit dir, logic [VW-1:0] dev, int start, int n);
    @(negedge clk);
    g0 = grants; s0 = strobes; src0 = src_idx; o0 = out_n;
    x_n = n; x_start = start; x_dir = dir;
    mon_base = start; mon_dev = dev; snap = strobes;
    for (int i = 0; i < n; i++)
      if (dir) exp_mem[(start + i) % MEMN] = dev_word(src0 + i);
    cfg_write(2'd0, FW'(start));
    cfg_write(2'd1, FW'(n));
    cfg_write(2'd2, FW'({dev, dir}));
    check(busy == 1'b1, "R2", "busy after control write", busy, 1);
  endtask

  task automatic finish_xfer();
    int mism = 0;
    for (int k = 0; k < 4000 && !irq; k++) @(negedge clk);
    check(irq == 1'b1, "R8", "irq at block end", irq, 1);
    check(busy == 1'b0, "R8", "busy falls with irq", busy, 0);
    check(strobes - s0 == x_n, "R8", "words moved", strobes - s0, x_n);
    check(grants - g0 == x_n, "R4", "one request per word", grants - g0, x_n);
    repeat (2) @(negedge clk);
    for (int i = 0; i < MEMN; i++) if (mem[i] != exp_mem[i]) mism++;
    check(mism == 0, "R6", "memory image mismatches", mism, 0);
    if (!x_dir) begin
      int om = 0;
      for (int i = 0; i < x_n; i++)
        if (out_buf[(o0 + i) % 256] != exp_mem[(x_start + i) % MEMN]) om++;
      check(out_n - o0 == x_n, "R6", "port words written", out_n - o0, x_n);
      check(om == 0, "R6", "port data mismatches", om, 0);
    end else
      check(src_idx - src0 == x_n, "R6", "port words read", src_idx - src0, x_n);
    check(irq == 1'b1, "R10", "irq still held", irq, 1);
    cfg_write(2'd3, '0);
    check(irq == 1'b0, "R10", "irq after clear", irq, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMN; i++) begin mem[i] = mem_word(i); exp_mem[i] = mem_word(i); end
    repeat (3) @(negedge clk);
    check(hold == 0 && irq == 0 && busy == 0, "R1", "reset outputs", {hold, irq, busy}, 0);
    check(mem_addr == 0 && !mem_we && !mem_re && !dev_rd && !dev_wr, "R1", "reset bus", mem_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // zero count
    g0 = grants;
    cfg_write(2'd1, '0);
    cfg_write(2'd2, FW'({4'd3, 1'b1}));
    check(irq == 1'b1, "R9", "irq on empty block", irq, 1);
    repeat (10) @(negedge clk);
    check(grants == g0, "R9", "no request on empty block", grants - g0, 0);
    check(irq == 1'b1, "R10", "irq held while pending", irq, 1);
    cfg_write(2'd3, '0);
    check(irq == 1'b0, "R10", "irq cleared", irq, 0);

    // directed: inbound, single word outbound, address wrap
    start_xfer(1'b1, 4'd5, 5, 4);   finish_xfer();
    start_xfer(1'b0, 4'd9, 40, 1);  finish_xfer();
    start_xfer(1'b1, 4'd2, MEMN - 2, 5); finish_xfer(); // R5 wrap

    // R7: port not ready, no request
    ready_block = 1'b1;
    repeat (3) @(negedge clk);
    start_xfer(1'b0, 4'd7, 100, 3);
    repeat (20) @(negedge clk);
    check(hold == 1'b0, "R7", "hold while port idle", hold, 0);
    check(grants == g0, "R7", "requests while port idle", grants - g0, 0);
    ready_block = 1'b0;
    finish_xfer();

    // R11: writes during a block are ignored
    start_xfer(1'b1, 4'd12, 300, 10);
    cfg_write(2'd0, FW'(777));
    cfg_write(2'd1, FW'(2));
    cfg_write(2'd2, FW'({4'd1, 1'b0}));
    cfg_write(2'd3, '0);
    check(busy == 1'b1, "R11", "still busy after stray writes", busy, 1);
    finish_xfer();

    // random blocks
    for (int t = 0; t < 10; t++) begin
      automatic bit d = 1'($urandom % 2);
      automatic int n = 1 + int'($urandom % 12);
      automatic int s = int'($urandom % MEMN);
      start_xfer(d, VW'($urandom), s, n);
      finish_xfer();
    end

    check(drive_err == 0, "R3", "bus driven without grant", drive_err, 0);
    check(addr_err == 0, "R5", "address or id errors", addr_err, 0);
    check(dir_err == 0, "R6", "direction pairing errors", dir_err, 0);
    check(multi_err == 0, "R4", "extra words per grant", multi_err, 0);
    check(pace_err == 0, "R7", "unpaced requests", pace_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule